// File: doc/BRIEF.md
# Second-Order Delta-Sigma Audio Modulator

This block turns a stream of signed 16-bit audio samples into a single-wire pulse stream for a mono audio output. A 1-bit modulator with two integrators is clocked by a timer tick enable and updates its output bit once every 4 or 8 ticks. A programmable terminal count sets the sample period. A new sample is taken only when the period counter wraps, so the terminal count alone fixes the sample rate. No prescaler is involved.

Between two accepted samples, a first-order interpolator ramps the modulator input from the previous sample to the current one. The step size is the sample difference divided by the number of modulator updates in one sample period. This division compensates for the gain that would otherwise depend on the ratio of sample rate to modulator rate. One select bit bypasses the ramp and holds each sample (zeroth order).

A second select bit turns on an output shaper. With the shaper on, every modulator bit has exactly one rising edge and one falling edge. This bounds the duty per bit to 1/8..7/8 at the slow rate and to 1/4..3/4 at the fast rate.

Top module: `dsm_audio`

## Requirements
- R1: While reset is asserted, and right after it is released with the shaper off, the output is low.
- R2: With the shaper off and a constant sample x (16-bit two's complement, a high output meaning positive full scale), the long-run fraction of ticks with the output high is (x+32768)/65536, within 3 percentage points.
- R3: The integrators saturate at 20 bits signed instead of wrapping. Sample 32767 gives at least 95% high ticks and sample -32768 gives at most 5%.
- R4: rate_sel=0 makes a modulator bit last 4 ticks and rate_sel=1 makes it last 8 ticks. With the shaper off, the output changes only after a tick count since reset that is a multiple of that length.
- R5: While tick_en is low, the output and all counting and modulator state hold.
- R6: A strobed sample has no effect on the output until the period counter wraps. The counter counts ticks 0..term_cnt and wraps on the tick where it equals term_cnt.
- R7: With mode_sel[1]=0, during the period after a new sample is accepted, the modulator input ramps linearly from the old sample to the new one. The step is (new-old) divided by (term_cnt+1)/4 or (term_cnt+1)/8.
- R8: With mode_sel[1]=1, the modulator input is the accepted sample held for the whole period.
- R9: With mode_sel[0]=1, every modulator bit period contains exactly one rising edge. The output is high in the first tick slot of each bit and low in the last.
- R10: With mode_sel[0]=1, a 1 bit is high for all slots except the last, and a 0 bit is high only in the first slot. No high or low run exceeds 7 ticks at rate_sel=1 or 3 ticks at rate_sel=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick enable; all state advances only on a tick |
| smp_data | input | 16 | Signed audio sample |
| smp_stb | input | 1 | Captures smp_data as the pending sample |
| term_cnt | input | 16 | Terminal count; sample period is term_cnt+1 ticks |
| rate_sel | input | 1 | 0: bit every 4 ticks, 1: bit every 8 ticks |
| mode_sel | input | 2 | Bit 1: hold sample (no ramp); bit 0: output shaper on |
| pwm_out | output | 1 | Modulated 1-bit output |

## Verification
Constant samples at zero, at half scale of either sign and at intermediate levels are applied at both rates and in both interpolation modes. The measured high-tick density shows whether the two-integrator loop tracks the input level. Full-scale samples of either sign show whether the integrators saturate or wrap. The interpolation test takes one step from zero to half scale over a long period: the period density lands near the ramp average with the ramp on and near the new level with hold, which separates the two orders. The shaper runs are judged by counting rising edges per bit and the longest high and low runs, and the tick-gating run watches the output while ticks are withheld.

// File: rtl/dsm_audio.sv
module dsm_audio #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int IW   = 20,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [DW-1:0] smp_data,
  input  logic          smp_stb,
  input  logic [CW-1:0] term_cnt,
  input  logic          rate_sel,
  input  logic [1:0]    mode_sel,
  output logic          pwm_out
);

  localparam int SW   = DW + FRAC + 1;
  localparam int IPW  = SW + 1;
  localparam int EW   = IW + 2;
  localparam int FSI  = 1 << (DW - 1);
  localparam int SATI = (1 << (IW - 1)) - 1;

  localparam logic signed [EW-1:0]  FS_P   = EW'(FSI);
  localparam logic signed [EW-1:0]  SAT_HI = EW'(SATI);
  localparam logic signed [EW-1:0]  SAT_LO = -SAT_HI - EW'(1);
  localparam logic signed [IPW-1:0] SMP_HI = IPW'(FSI - 1);
  localparam logic signed [IPW-1:0] SMP_LO = -SMP_HI - IPW'(1);

  logic [2:0]              slot_q;
  logic [CW-1:0]           per_q;
  logic signed [DW-1:0]    pend_q, cur_q;
  logic signed [SW-1:0]    step_q;
  logic signed [IPW-1:0]   interp_q;
  logic signed [IW-1:0]    i1_q, i2_q;
  logic                    bit_q;

  logic [2:0]              last;
  logic                    upd, wrap;
  logic [CW:0]             n_upd, n_safe;
  logic signed [DW:0]      diff;
  logic signed [SW-1:0]    scaled, den, step_n;
  logic signed [IPW-1:0]   ipart;
  logic signed [DW-1:0]    interp_x, x_in;
  logic signed [EW-1:0]    x_ext, fb;
  logic signed [IW-1:0]    i1_n, i2_n;

  function automatic logic signed [EW-1:0] ext(input logic signed [IW-1:0] v);
    return $signed({{2{v[IW-1]}}, v});
  endfunction

  function automatic logic signed [IW-1:0] sat(input logic signed [EW-1:0] v);
    if (v > SAT_HI) return SAT_HI[IW-1:0];
    if (v < SAT_LO) return SAT_LO[IW-1:0];
    return v[IW-1:0];
  endfunction

  assign last = rate_sel ? 3'd7 : 3'd3;
  assign upd  = tick_en && (slot_q == last);
  assign wrap = tick_en && (per_q >= term_cnt);

  assign n_upd  = ({1'b0, term_cnt} + (CW+1)'(1)) >> (rate_sel ? 3 : 2);
  assign n_safe = (n_upd == '0) ? (CW+1)'(1) : n_upd;
  assign diff   = $signed({pend_q[DW-1], pend_q}) - $signed({cur_q[DW-1], cur_q});
  assign scaled = $signed({diff, {FRAC{1'b0}}});
  assign den    = $signed({{(SW-CW-1){1'b0}}, n_safe});
  assign step_n = scaled / den;

  assign ipart    = interp_q >>> FRAC;
  assign interp_x = (ipart > SMP_HI) ? SMP_HI[DW-1:0] :
                    (ipart < SMP_LO) ? SMP_LO[DW-1:0] : ipart[DW-1:0];
  assign x_in  = mode_sel[1] ? cur_q : interp_x;
  assign x_ext = $signed({{(EW-DW){x_in[DW-1]}}, x_in});
  assign fb    = bit_q ? FS_P : -FS_P;
  assign i1_n  = sat(ext(i1_q) + x_ext - fb);
  assign i2_n  = sat(ext(i2_q) + ext(i1_n) - fb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      per_q    <= '0;
      pend_q   <= '0;
      cur_q    <= '0;
      step_q   <= '0;
      interp_q <= '0;
      i1_q     <= '0;
      i2_q     <= '0;
      bit_q    <= 1'b0;
    end else begin
      if (smp_stb) pend_q <= smp_data;
      if (tick_en) begin
        per_q  <= wrap ? '0 : per_q + 1'b1;
        slot_q <= upd ? 3'd0 : slot_q + 3'd1;
      end
      if (wrap) begin
        cur_q    <= pend_q;
        step_q   <= step_n;
        interp_q <= $signed({{2{cur_q[DW-1]}}, cur_q, {FRAC{1'b0}}});
      end else if (upd) begin
        interp_q <= interp_q + $signed({step_q[SW-1], step_q});
      end
      if (upd) begin
        i1_q  <= i1_n;
        i2_q  <= i2_n;
        bit_q <= !i2_n[IW-1];
      end
    end
  end

  assign pwm_out = mode_sel[0] ? (bit_q ? (slot_q != last) : (slot_q == 3'd0)) : bit_q;

endmodule

module dsm_audio_chk #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          rate_sel,
  input logic [1:0]    mode_sel,
  input logic [CW-1:0] term_cnt,
  input logic [CW-1:0] per_q,
  input logic [DW-1:0] cur_q,
  input logic [2:0]    slot_q,
  input logic          bit_q,
  input logic          pwm_out
);
  logic [2:0] lst;
  assign lst = rate_sel ? 3'd7 : 3'd3;

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(slot_q) && $stable(bit_q) && $stable(per_q)));

  p_slot_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && slot_q == lst) |=> (slot_q == 3'd0));

  p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && slot_q != lst) |=> $stable(bit_q));

  p_sample_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_en && per_q >= term_cnt) |=> $stable(cur_q));

  p_first_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[0] && slot_q == 3'd0) |-> pwm_out);

  p_last_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[0] && slot_q == lst) |-> !pwm_out);
endmodule

bind dsm_audio dsm_audio_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_sel(rate_sel),
  .mode_sel(mode_sel), .term_cnt(term_cnt), .per_q(per_q), .cur_q(cur_q),
  .slot_q(slot_q), .bit_q(bit_q), .pwm_out(pwm_out)
);

// File: tb/dsm_audio_test.sv
module dsm_audio_test;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [15:0] smp_data = '0;
  logic        smp_stb = 1'b0;
  logic [15:0] term_cnt = 16'd63;
  logic        rate_sel = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic        pwm_out;

  int total = 0;
  int bad = 0;

  // {sample[28:13], rate[12], mode[11:10], expected per-mille[9:0]}
  localparam logic [28:0] VEC [6] = '{
    {16'h0000, 1'b0, 2'b00, 10'd500},
    {16'h4000, 1'b0, 2'b00, 10'd750},
    {16'hC000, 1'b1, 2'b00, 10'd250},
    {16'h2000, 1'b1, 2'b10, 10'd625},
    {16'hE000, 1'b0, 2'b10, 10'd375},
    {16'h6000, 1'b1, 2'b00, 10'd875}
  };

  dsm_audio uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .smp_data(smp_data),
    .smp_stb(smp_stb), .term_cnt(term_cnt), .rate_sel(rate_sel),
    .mode_sel(mode_sel), .pwm_out(pwm_out)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic r, input logic [1:0] m, input logic [15:0] t);
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b1; smp_stb = 1'b0;
    rate_sel = r; mode_sel = m; term_cnt = t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic strobe(input logic [15:0] x);
    tick_en = 1'b0; smp_data = x; smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0; tick_en = 1'b1;
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(posedge clk); @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic shaper_run(input logic r, input logic [15:0] x, input string t9, input string t10);
    int d, k, rises, hr, lr, mh, ml;
    logic prev;
    d = r ? 8 : 4; k = 200;
    do_reset(r, 2'b01, 16'd63);
    rises = 0; hr = 0; lr = 0; mh = 0; ml = 0; prev = 1'b0;
    for (int j = 0; j < d * k; j++) begin
      if (pwm_out && !prev) rises++;
      if (pwm_out) begin hr++; lr = 0; end else begin lr++; hr = 0; end
      if (hr > mh) mh = hr;
      if (lr > ml) ml = lr;
      prev = pwm_out;
      @(posedge clk); @(negedge clk);
    end
    check(rises == k, t9, rises, k);
    check(mh <= d - 1 && ml <= d - 1, t10, (mh > ml) ? mh : ml, d - 1);
    if (x != 16'h0) ;
  endtask

  task automatic edge_run(input logic r, input string tag);
    int d, viol, chg;
    logic prev;
    d = r ? 8 : 4;
    do_reset(r, 2'b00, 16'd63);
    strobe(16'h0000);
    viol = 0; chg = 0; prev = pwm_out;
    for (int j = 1; j <= 800; j++) begin
      @(posedge clk); @(negedge clk);
      if (pwm_out != prev) begin
        chg++;
        if ((j % d) != 0) viol++;
      end
      prev = pwm_out;
    end
    check(viol == 0 && chg > 0, tag, viol, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int h, pm, ex;
    logic snap;

    // R1: reset state
    do_reset(1'b0, 2'b00, 16'd63);
    check(pwm_out == 1'b0, "R1 out low after reset", pwm_out, 0);

    // R2: density table walk
    foreach (VEC[i]) begin
      do_reset(VEC[i][12], VEC[i][11:10], 16'd63);
      strobe(VEC[i][28:13]);
      count_high(512, h);
      count_high(4096, h);
      pm = h * 1000 / 4096;
      ex = int'(VEC[i][9:0]);
      check(absd(pm, ex) <= 30, $sformatf("R2 density row %0d", i), pm, ex);
    end

    // R3: full-scale saturation
    do_reset(1'b0, 2'b10, 16'd63);
    strobe(16'h7FFF);
    count_high(512, h);
    count_high(4096, h);
    pm = h * 1000 / 4096;
    check(pm >= 950, "R3 positive full scale", pm, 950);
    do_reset(1'b1, 2'b10, 16'd63);
    strobe(16'h8000);
    count_high(512, h);
    count_high(4096, h);
    pm = h * 1000 / 4096;
    check(pm <= 50, "R3 negative full scale", pm, 50);

    // R4: bit boundaries at both rates
    edge_run(1'b0, "R4 changes on 4-tick boundary");
    edge_run(1'b1, "R4 changes on 8-tick boundary");

    // R5: tick gating freezes output
    do_reset(1'b0, 2'b01, 16'd63);
    strobe(16'h1000);
    repeat (37) @(negedge clk);
    tick_en = 1'b0;
    snap = pwm_out;
    h = 0;
    repeat (50) begin
      @(negedge clk);
      if (pwm_out != snap) h++;
    end
    tick_en = 1'b1;
    check(h == 0, "R5 frozen without ticks", h, 0);

    // R6, R7: long period, ramp on
    do_reset(1'b0, 2'b00, 16'd4095);
    strobe(16'h4000);
    count_high(4096, h);
    pm = h * 1000 / 4096;
    check(absd(pm, 500) <= 30, "R6 sample unused before wrap", pm, 500);
    count_high(4096, h);
    pm = h * 1000 / 4096;
    check(absd(pm, 625) <= 30, "R7 ramp average", pm, 625);

    // R8: same step with hold
    do_reset(1'b0, 2'b10, 16'd4095);
    strobe(16'h4000);
    count_high(4096, h);
    count_high(4096, h);
    pm = h * 1000 / 4096;
    check(absd(pm, 750) <= 30, "R8 held sample level", pm, 750);

    // R9, R10: shaper at both rates
    shaper_run(1'b0, 16'h0000, "R9 one rise per 4-tick bit", "R10 runs at rate 1/4");
    shaper_run(1'b1, 16'h0000, "R9 one rise per 8-tick bit", "R10 runs at rate 1/8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule